// File: doc/BRIEF.md
# L2 Address Table Entry Manager

This block keeps a small forwarding table of unicast and multicast station entries in flip-flops and runs table commands against it. Every entry is six 16-bit words packed into one 96-bit vector (word 0 in bits 15:0, word 5 in bits 95:80). The lookup key is the 48-bit MAC address plus the 12-bit VLAN ID. There is no separate valid flag: whether a slot is in use is decided from the entry's own contents.

A command is started with a one-cycle `cmd_start` pulse. Three operations exist: write, which adds, updates or removes an entry; read by exact key; and a walk that returns the next unicast entry belonging to a given port. The controller scans one slot per clock. It reports the result with a one-cycle `done` pulse, together with `ok` or `not_found`, the slot index and the entry.

The walk wraps around the end of the table. A caller iterating over a port therefore recognises the end of its pass when a returned index is not above the index it started from.

Top module: `l2_entry_table`

## Requirements
- R1: The key is the MAC address in words 0 to 2 plus the VLAN ID in word 3 bits 11:0. The MAC occupies entry bits 47:0, with MAC byte 0 in bits 47:40. Entry bit 40 (the group bit) marks an entry as multicast. Two entries with the same MAC and different VLAN IDs occupy different slots.
- R2: A unicast entry is valid when its age (word 4 bits 13:11) is nonzero. A multicast entry is valid when its 11-bit member mask is nonzero or its static bit (word 5 bit 5) is set. The member mask is built from word 5 bit 7 as bit 10, word 3 bits 15:14 as bits 9:8, and word 4 bits 7:0 as bits 7:0.
- R3: A write whose entry is valid and whose key matches no valid slot goes into the lowest-numbered invalid slot. This happens only after every slot has been scanned. The write reports ok with that index.
- R4: A write whose key matches a valid slot overwrites that slot and reports ok with its index. This also works when the table is full.
- R5: A valid write that matches no key while no slot is free reports not_found and changes no slot.
- R6: A write whose entry is invalid by R2 removes a matching slot, leaving it invalid, and reports ok with its index. If no slot matches, it reports not_found.
- R7: A read (cmd_op 1; code 3 acts the same) returns the stored entry and index of the valid slot whose key matches. With no such slot it reports not_found.
- R8: A walk (cmd_op 2) starts at cmd_index and visits every slot once, wrapping past the last slot. It returns the first valid unicast entry whose port, {word 3 bit 15, word 4 bits 10:8}, equals cmd_port. Multicast and invalid slots are skipped.
- R9: When a command reports not_found, rsp_index and rsp_entry keep their previous values.
- R10: done is a one-cycle pulse that arrives within DEPTH+1 cycles of an accepted start, with exactly one of ok and not_found. No status is driven outside done. A start received while busy is ignored.
- R11: After reset, busy, done, ok, not_found, rsp_index and rsp_entry are zero, and every slot holds all-zero (invalid) content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | One-cycle command request, accepted when not busy |
| cmd_op | input | 2 | 0 write, 1 read by key, 2 walk by port, 3 read |
| cmd_entry | input | 96 | Entry to write, or probe holding the key |
| cmd_index | input | $clog2(DEPTH) | First slot visited by a walk |
| cmd_port | input | 4 | Port filter for a walk |
| busy | output | 1 | A scan is in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Command succeeded, valid with done |
| not_found | output | 1 | No match, or no free slot, valid with done |
| rsp_index | output | $clog2(DEPTH) | Slot touched by the last successful command |
| rsp_entry | output | 96 | Entry read, found or written by the last successful command |

## Verification
Two things can meet in the same cycle: a new start request and a scan already in progress. The bench provokes this by starting a full-table read for a missing key and then, two cycles later, pulsing start again with a write of a fresh entry. It judges the outcome at the ports. Exactly one done pulse must appear, it must carry the read's not_found, and a later read of the fresh key must also report not_found, which shows that the second request touched nothing.

// File: rtl/l2tab_pkg.sv
// Package for the L2 address table.
// Purpose: defines the entry layout, the command codes and the field decode
// helpers that the controller, the slot evaluator and the checker share.
// Assumes: an entry is six 16-bit words, with word k held in bits [16k+15:16k].
package l2tab_pkg;

    localparam int WORD_W    = 16;
    localparam int ENT_WORDS = 6;
    localparam int ENT_W     = WORD_W * ENT_WORDS;
    localparam int MAC_W     = 48;
    localparam int VID_W     = 12;
    localparam int KEY_W     = MAC_W + VID_W;
    localparam int PORT_W    = 4;
    localparam int MASK_W    = 11;
    localparam int AGE_W     = 3;

    typedef logic [ENT_W-1:0] entry_t;
    typedef logic [KEY_W-1:0] key_t;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_WALK  = 2'd2
    } op_e;

    // Return word k of an entry.
    function automatic logic [WORD_W-1:0] ent_word(entry_t e, int k);
        return e[k*WORD_W +: WORD_W];
    endfunction

    // Return the lookup key: the MAC address and the VLAN ID.
    function automatic key_t ent_key(entry_t e);
        logic [WORD_W-1:0] w3;
        w3 = ent_word(e, 3);
        return {e[MAC_W-1:0], w3[VID_W-1:0]};
    endfunction

    // Return the group bit: bit 0 of MAC byte 0.
    function automatic logic ent_is_group(entry_t e);
        return e[40];
    endfunction

    // Return the 4-bit unicast port, which is split across words 3 and 4.
    function automatic logic [PORT_W-1:0] ent_uc_port(entry_t e);
        logic [WORD_W-1:0] w3;
        logic [WORD_W-1:0] w4;
        w3 = ent_word(e, 3);
        w4 = ent_word(e, 4);
        return {w3[15], w4[10:8]};
    endfunction

    // Return the unicast age.
    function automatic logic [AGE_W-1:0] ent_age(entry_t e);
        logic [WORD_W-1:0] w4;
        w4 = ent_word(e, 4);
        return w4[13:11];
    endfunction

    // Return the 11-bit multicast member mask, gathered from three words.
    function automatic logic [MASK_W-1:0] ent_mc_mask(entry_t e);
        logic [WORD_W-1:0] w3;
        logic [WORD_W-1:0] w4;
        logic [WORD_W-1:0] w5;
        w3 = ent_word(e, 3);
        w4 = ent_word(e, 4);
        w5 = ent_word(e, 5);
        return {w5[7], w3[15:14], w4[7:0]};
    endfunction

    // Return the static flag.
    function automatic logic ent_static(entry_t e);
        logic [WORD_W-1:0] w5;
        w5 = ent_word(e, 5);
        return w5[5];
    endfunction

    // Decide from content alone whether an entry occupies its slot.
    function automatic logic ent_valid(entry_t e);
        if (ent_is_group(e)) begin
            return (ent_mc_mask(e) != '0) || ent_static(e);
        end
        return ent_age(e) != '0;
    endfunction

endpackage

// File: rtl/l2tab_store.sv
// Entry storage for the L2 address table.
// Purpose: DEPTH entry registers, with one synchronous write port and one
// combinational read port.
// Assumes: reset clears every slot to zero, and zero content decodes as an
// invalid unicast entry.
module l2tab_store #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  l2tab_pkg::entry_t       wr_data,
    input  logic [IDX_W-1:0]        rd_idx,
    output l2tab_pkg::entry_t       rd_data
);

    l2tab_pkg::entry_t slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        l2tab_pkg::entry_t q;

        // Hold one slot and load it when the write port addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                q <= wr_data;
            end
        end

        assign slot_q[g] = q;
    end

    // Present the slot under the scan pointer.
    assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/l2tab_slot_eval.sv
// Slot evaluator for the L2 address table.
// Purpose: classifies the slot under the scan pointer against the command
// being run: whether it is valid, whether its key matches the probe, and
// whether it satisfies the port filter of a walk.
// Assumes: a key match counts only on a valid slot.
module l2tab_slot_eval (
    input  l2tab_pkg::entry_t               slot,
    input  l2tab_pkg::entry_t               probe,
    input  logic [l2tab_pkg::PORT_W-1:0]    port,
    output logic                            slot_valid,
    output logic                            key_hit,
    output logic                            walk_hit
);

    import l2tab_pkg::*;

    // Decode the slot and compare it with the command.
    always_comb begin
        slot_valid = ent_valid(slot);
        key_hit    = slot_valid && (ent_key(slot) == ent_key(probe));
        walk_hit   = slot_valid && !ent_is_group(slot) && (ent_uc_port(slot) == port);
    end

endmodule

// File: rtl/l2tab_ctrl.sv
// Command controller for the L2 address table.
// Purpose: accepts one command at a time, steps the scan pointer one slot
// per clock, tracks the lowest free slot for adds, drives the storage write
// port and registers the response.
// Assumes: storage reads are combinational; a write scan always starts at
// slot 0, so the first invalid slot it sees is the lowest one.
module l2tab_ctrl #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cmd_start,
    input  logic [1:0]                      cmd_op,
    input  l2tab_pkg::entry_t               cmd_entry,
    input  logic [IDX_W-1:0]                cmd_index,
    input  logic [l2tab_pkg::PORT_W-1:0]    cmd_port,
    input  l2tab_pkg::entry_t               slot,
    input  logic                            slot_valid,
    input  logic                            key_hit,
    input  logic                            walk_hit,
    output l2tab_pkg::entry_t               probe,
    output logic [l2tab_pkg::PORT_W-1:0]    probe_port,
    output logic [IDX_W-1:0]                scan_idx,
    output logic                            wr_en,
    output logic [IDX_W-1:0]                wr_idx,
    output l2tab_pkg::entry_t               wr_data,
    output logic                            busy,
    output logic                            done,
    output logic                            ok,
    output logic                            not_found,
    output logic [IDX_W-1:0]                rsp_index,
    output l2tab_pkg::entry_t               rsp_entry
);

    import l2tab_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    typedef enum logic {ST_IDLE, ST_SCAN} state_e;

    state_e                 st_q;
    logic [1:0]             op_q;
    entry_t                 ent_q;
    logic [PORT_W-1:0]      port_q;
    logic [IDX_W-1:0]       ptr_q;
    logic [IDX_W-1:0]       cnt_q;
    logic                   free_vld_q;
    logic [IDX_W-1:0]       free_idx_q;
    logic                   done_q;
    logic                   ok_q;
    logic                   nf_q;
    logic [IDX_W-1:0]       idx_q;
    entry_t                 rsp_q;

    logic                   is_wr;
    logic                   is_walk;
    logic                   hit;
    logic                   last;
    logic                   can_add;
    logic                   finish;
    logic                   success;
    logic [IDX_W-1:0]       ptr_nxt;
    logic [IDX_W-1:0]       tgt_idx;

    // Combine the slot result with the command and the scan position.
    always_comb begin
        is_wr   = (op_q == OP_WRITE);
        is_walk = (op_q == OP_WALK);
        hit     = is_walk ? walk_hit : key_hit;
        last    = (cnt_q == LAST_IDX);
        can_add = ent_valid(ent_q) && (free_vld_q || !slot_valid);
        finish  = (st_q == ST_SCAN) && (hit || last);
        success = hit || (is_wr && can_add);
        ptr_nxt = (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
        tgt_idx = hit ? ptr_q : (free_vld_q ? free_idx_q : ptr_q);
        wr_en   = finish && is_wr && success;
        wr_idx  = tgt_idx;
        wr_data = ent_q;
    end

    // Sequence the command: accept it, scan the slots, then report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            op_q       <= '0;
            ent_q      <= '0;
            port_q     <= '0;
            ptr_q      <= '0;
            cnt_q      <= '0;
            free_vld_q <= 1'b0;
            free_idx_q <= '0;
            done_q     <= 1'b0;
            ok_q       <= 1'b0;
            nf_q       <= 1'b0;
            idx_q      <= '0;
            rsp_q      <= '0;
        end else begin
            done_q <= 1'b0;
            ok_q   <= 1'b0;
            nf_q   <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (cmd_start) begin
                        st_q       <= ST_SCAN;
                        op_q       <= cmd_op;
                        ent_q      <= cmd_entry;
                        port_q     <= cmd_port;
                        ptr_q      <= (cmd_op == OP_WALK) ? cmd_index : '0;
                        cnt_q      <= '0;
                        free_vld_q <= 1'b0;
                    end
                end
                default: begin
                    if (finish) begin
                        st_q   <= ST_IDLE;
                        done_q <= 1'b1;
                        if (success) begin
                            ok_q  <= 1'b1;
                            idx_q <= tgt_idx;
                            rsp_q <= is_wr ? ent_q : slot;
                        end else begin
                            nf_q <= 1'b1;
                        end
                    end else begin
                        ptr_q <= ptr_nxt;
                        cnt_q <= cnt_q + 1'b1;
                        if (!slot_valid && !free_vld_q) begin
                            free_vld_q <= 1'b1;
                            free_idx_q <= ptr_q;
                        end
                    end
                end
            endcase
        end
    end

    assign probe      = ent_q;
    assign probe_port = port_q;
    assign scan_idx   = ptr_q;
    assign busy       = (st_q == ST_SCAN);
    assign done       = done_q;
    assign ok         = ok_q;
    assign not_found  = nf_q;
    assign rsp_index  = idx_q;
    assign rsp_entry  = rsp_q;

endmodule

// File: rtl/l2_entry_table.sv
// L2 address table entry manager (top level).
// Purpose: connects the storage, the slot evaluator and the command
// controller into one table that runs write, read-by-key and walk-by-port
// commands.
// Assumes: DEPTH >= 2; one command at a time; slot validity comes only from
// the stored content.
module l2_entry_table #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_start,
    input  logic [1:0]          cmd_op,
    input  logic [95:0]         cmd_entry,
    input  logic [IDX_W-1:0]    cmd_index,
    input  logic [3:0]          cmd_port,
    output logic                busy,
    output logic                done,
    output logic                ok,
    output logic                not_found,
    output logic [IDX_W-1:0]    rsp_index,
    output logic [95:0]         rsp_entry
);

    import l2tab_pkg::*;

    entry_t             slot;
    entry_t             probe;
    logic [PORT_W-1:0]  probe_port;
    logic [IDX_W-1:0]   scan_idx;
    logic               slot_valid;
    logic               key_hit;
    logic               walk_hit;
    logic               wr_en;
    logic [IDX_W-1:0]   wr_idx;
    entry_t             wr_data;

    l2tab_store #(.DEPTH(DEPTH)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (scan_idx),
        .rd_data (slot)
    );

    l2tab_slot_eval i_eval (
        .slot       (slot),
        .probe      (probe),
        .port       (probe_port),
        .slot_valid (slot_valid),
        .key_hit    (key_hit),
        .walk_hit   (walk_hit)
    );

    l2tab_ctrl #(.DEPTH(DEPTH)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_start  (cmd_start),
        .cmd_op     (cmd_op),
        .cmd_entry  (cmd_entry),
        .cmd_index  (cmd_index),
        .cmd_port   (cmd_port),
        .slot       (slot),
        .slot_valid (slot_valid),
        .key_hit    (key_hit),
        .walk_hit   (walk_hit),
        .probe      (probe),
        .probe_port (probe_port),
        .scan_idx   (scan_idx),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .busy       (busy),
        .done       (done),
        .ok         (ok),
        .not_found  (not_found),
        .rsp_index  (rsp_index),
        .rsp_entry  (rsp_entry)
    );

endmodule

// File: rtl/l2tab_checker.sv
// Property checker for the L2 address table, bound to the top module.
// Purpose: watches the command and response ports and checks the status
// protocol, the scan bound and the consistency of reported hits.
// Assumes: a start is accepted exactly when it arrives while busy is low.
module l2tab_checker #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_start,
    input  logic [1:0]          cmd_op,
    input  logic [95:0]         cmd_entry,
    input  logic [3:0]          cmd_port,
    input  logic                busy,
    input  logic                done,
    input  logic                ok,
    input  logic                not_found,
    input  logic [IDX_W-1:0]    rsp_index,
    input  logic [95:0]         rsp_entry
);

    import l2tab_pkg::*;

    logic [1:0]             op_c;
    key_t                   key_c;
    logic [PORT_W-1:0]      port_c;
    logic [IDX_W:0]         busy_cnt;

    // Capture the command that was accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_c   <= '0;
            key_c  <= '0;
            port_c <= '0;
        end else if (cmd_start && !busy) begin
            op_c   <= cmd_op;
            key_c  <= ent_key(cmd_entry);
            port_c <= cmd_port;
        end
    end

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (busy) begin
            busy_cnt <= busy_cnt + 1'b1;
        end else begin
            busy_cnt <= '0;
        end
    end

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_status_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ok ^ not_found));

    p_status_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!ok && !not_found));

    p_done_after_scan_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_scan_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt < (IDX_W+1)'(DEPTH)));

    p_miss_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        not_found |-> ($stable(rsp_index) && $stable(rsp_entry)));

    p_walk_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ok && (op_c == OP_WALK)) |->
            (ent_valid(rsp_entry) && !ent_is_group(rsp_entry) && (ent_uc_port(rsp_entry) == port_c)));

    p_read_key_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ok && (op_c != OP_WALK)) |-> (ent_key(rsp_entry) == key_c));

endmodule

bind l2_entry_table l2tab_checker #(.DEPTH(DEPTH)) i_l2tab_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_start),
    .cmd_op    (cmd_op),
    .cmd_entry (cmd_entry),
    .cmd_port  (cmd_port),
    .busy      (busy),
    .done      (done),
    .ok        (ok),
    .not_found (not_found),
    .rsp_index (rsp_index),
    .rsp_entry (rsp_entry)
);

// File: tb/test_l2_entry_table.sv
module test_l2_entry_table;

    localparam int TB_DEPTH = 8;
    localparam int TIDX     = $clog2(TB_DEPTH);
    localparam int CLK_PER  = 10;
    localparam int NVEC     = 20;

    typedef struct packed {
        logic [1:0]      op;
        logic [95:0]     ent;
        logic [TIDX-1:0] idx;
        logic [3:0]      port;
        logic            exp_ok;
        logic [TIDX-1:0] exp_idx;
        logic            chk_ent;
        logic [95:0]     exp_ent;
    } vec_t;

    // Build a unicast entry: MAC, VLAN, port, age (IVL flag set).
    function automatic logic [95:0] uc(logic [47:0] mac, logic [11:0] vid,
                                       logic [3:0] port, logic [2:0] age);
        logic [15:0] w3;
        logic [15:0] w4;
        w3 = {port[3], 2'b00, 1'b1, vid};
        w4 = {1'b0, 1'b0, age, port[2:0], 8'h00};
        return {16'h0000, w4, w3, mac};
    endfunction

    // Build a multicast entry: MAC, VLAN, member mask, static, group index.
    function automatic logic [95:0] mc(logic [47:0] mac, logic [11:0] vid,
                                       logic [10:0] mask, logic stat, logic [7:0] gidx);
        logic [15:0] w3;
        logic [15:0] w4;
        logic [15:0] w5;
        w3 = {mask[9:8], 1'b1, 1'b0, vid};
        w4 = {gidx, mask[7:0]};
        w5 = {8'h00, mask[10], 1'b0, stat, 5'b00000};
        return {w5, w4, w3, mac};
    endfunction

    function automatic vec_t mk(logic [1:0] op, logic [95:0] ent, int idx, int port,
                                logic eok, int eidx, logic chk, logic [95:0] eent);
        vec_t v;
        v.op = op; v.ent = ent; v.idx = TIDX'(idx); v.port = 4'(port);
        v.exp_ok = eok; v.exp_idx = TIDX'(eidx); v.chk_ent = chk; v.exp_ent = eent;
        return v;
    endfunction

    localparam logic [47:0] MA = 48'h0011_2233_4455;
    localparam logic [47:0] MB = 48'h0011_2233_44AA;
    localparam logic [47:0] MG = 48'h0100_5E00_0001;
    localparam logic [47:0] MC = 48'h0011_2233_66CC;
    localparam logic [47:0] MZ = 48'h0022_0000_0001;

    localparam logic [95:0] U1  = uc(MA, 12'd10, 4'd3, 3'd1);
    localparam logic [95:0] U2  = uc(MB, 12'd10, 4'd9, 3'd2);
    localparam logic [95:0] M1  = mc(MG, 12'd10, 11'h400, 1'b0, 8'h00);
    localparam logic [95:0] U3  = uc(MA, 12'd20, 4'd3, 3'd3);
    localparam logic [95:0] U1B = uc(MA, 12'd10, 4'd5, 3'd7);
    localparam logic [95:0] U4  = uc(MC, 12'd10, 4'd1, 3'd4);
    localparam logic [95:0] M2  = mc(MG, 12'd10, 11'h000, 1'b1, 8'h03);

    localparam vec_t VECS [NVEC] = '{
        mk(2'd0, U1,  0, 0, 1'b1, 0, 1'b0, '0),
        mk(2'd0, U2,  0, 0, 1'b1, 1, 1'b0, '0),
        mk(2'd0, M1,  0, 0, 1'b1, 2, 1'b0, '0),
        mk(2'd0, U3,  0, 0, 1'b1, 3, 1'b0, '0),
        mk(2'd1, uc(MA, 12'd10, 4'd0, 3'd0), 0, 0, 1'b1, 0, 1'b1, U1),
        mk(2'd0, U1B, 0, 0, 1'b1, 0, 1'b0, '0),
        mk(2'd1, uc(MA, 12'd10, 4'd0, 3'd0), 0, 0, 1'b1, 0, 1'b1, U1B),
        mk(2'd2, '0,  0, 3, 1'b1, 3, 1'b1, U3),
        mk(2'd2, '0,  4, 5, 1'b1, 0, 1'b1, U1B),
        mk(2'd2, '0,  0, 9, 1'b1, 1, 1'b1, U2),
        mk(2'd2, '0,  0, 7, 1'b0, 0, 1'b0, '0),
        mk(2'd1, mc(MG, 12'd10, 11'h000, 1'b0, 8'h00), 0, 0, 1'b1, 2, 1'b1, M1),
        mk(2'd0, uc(MB, 12'd10, 4'd0, 3'd0), 0, 0, 1'b1, 1, 1'b0, '0),
        mk(2'd1, uc(MB, 12'd10, 4'd0, 3'd0), 0, 0, 1'b0, 0, 1'b0, '0),
        mk(2'd0, U4,  0, 0, 1'b1, 1, 1'b0, '0),
        mk(2'd0, uc(MZ, 12'd10, 4'd0, 3'd0), 0, 0, 1'b0, 0, 1'b0, '0),
        mk(2'd0, mc(MG, 12'd10, 11'h000, 1'b0, 8'h00), 0, 0, 1'b1, 2, 1'b0, '0),
        mk(2'd1, mc(MG, 12'd10, 11'h000, 1'b0, 8'h00), 0, 0, 1'b0, 0, 1'b0, '0),
        mk(2'd0, M2,  0, 0, 1'b1, 2, 1'b0, '0),
        mk(2'd2, '0,  2, 3, 1'b1, 3, 1'b1, U3)
    };

    // Requirement tag for each vector.
    function automatic string vtag(int k);
        case (k)
            0, 1, 2, 14:     return "R3";
            3, 11:           return "R1";
            5:               return "R4";
            4, 6:            return "R7";
            7, 8, 9, 10, 19: return "R8";
            12, 13, 15:      return "R6";
            default:         return "R2";
        endcase
    endfunction

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                cmd_start = 1'b0;
    logic [1:0]          cmd_op = '0;
    logic [95:0]         cmd_entry = '0;
    logic [TIDX-1:0]     cmd_index = '0;
    logic [3:0]          cmd_port = '0;
    logic                busy;
    logic                done;
    logic                ok;
    logic                not_found;
    logic [TIDX-1:0]     rsp_index;
    logic [95:0]         rsp_entry;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PER/2) clk = ~clk;

    l2_entry_table #(.DEPTH(TB_DEPTH)) i_l2_entry_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_start (cmd_start),
        .cmd_op    (cmd_op),
        .cmd_entry (cmd_entry),
        .cmd_index (cmd_index),
        .cmd_port  (cmd_port),
        .busy      (busy),
        .done      (done),
        .ok        (ok),
        .not_found (not_found),
        .rsp_index (rsp_index),
        .rsp_entry (rsp_entry)
    );

    task automatic check(string tag, string what, logic [95:0] act, logic [95:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Issue one command and wait until its done pulse (sampled at negedge).
    task automatic run(logic [1:0] op, logic [95:0] ent, logic [TIDX-1:0] idx,
                       logic [3:0] port, string tag);
        logic got;
        @(negedge clk);
        cmd_start = 1'b1; cmd_op = op; cmd_entry = ent; cmd_index = idx; cmd_port = port;
        @(negedge clk);
        cmd_start = 1'b0;
        got = 1'b0;
        for (int w = 0; w < TB_DEPTH + 4; w++) begin
            if (done) begin
                got = 1'b1;
                break;
            end
            @(negedge clk);
        end
        check(tag, "done seen", 96'(got), 96'(1));
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL R10 watchdog: actual=hung expected=finished");
        finish_up();
    end

    initial begin
        logic [TIDX-1:0] idx_before;
        logic [95:0]     ent_before;
        int              n_done;
        logic            nf_seen;

        repeat (3) @(negedge clk);
        // R11: reset state at the ports.
        check("R11", "busy", 96'(busy), 96'(0));
        check("R11", "done/ok/nf", 96'({done, ok, not_found}), 96'(0));
        check("R11", "rsp_index", 96'(rsp_index), 96'(0));
        check("R11", "rsp_entry", rsp_entry, '0);
        rst_n = 1'b1;
        // R11: an all-zero key is not found in a cleared table.
        run(2'd1, '0, '0, '0, "R11");
        check("R11", "zero key not found", 96'(not_found), 96'(1));

        for (int k = 0; k < NVEC; k++) begin
            run(VECS[k].op, VECS[k].ent, VECS[k].idx, VECS[k].port, vtag(k));
            check(vtag(k), $sformatf("vec %0d ok", k), 96'(ok), 96'(VECS[k].exp_ok));
            check(vtag(k), $sformatf("vec %0d not_found", k), 96'(not_found), 96'(!VECS[k].exp_ok));
            if (VECS[k].exp_ok)
                check(vtag(k), $sformatf("vec %0d index", k), 96'(rsp_index), 96'(VECS[k].exp_idx));
            if (VECS[k].chk_ent)
                check(vtag(k), $sformatf("vec %0d entry", k), rsp_entry, VECS[k].exp_ent);
        end

        // R3: fill free slots 4..7 in ascending order.
        for (int i = 0; i < 4; i++) begin
            run(2'd0, uc(48'h0000_0000_1000 + 48'(i), 12'd30, 4'd2, 3'd1), '0, '0, "R3");
            check("R3", "fill ok", 96'(ok), 96'(1));
            check("R3", "fill index", 96'(rsp_index), 96'(4 + i));
        end
        // R5: table full, a new key is refused.
        run(2'd0, uc(48'h0000_0000_2000, 12'd30, 4'd2, 3'd1), '0, '0, "R5");
        check("R5", "full not_found", 96'(not_found), 96'(1));
        run(2'd1, uc(48'h0000_0000_2000, 12'd30, 4'd0, 3'd0), '0, '0, "R5");
        check("R5", "refused key absent", 96'(not_found), 96'(1));
        // R4: update still works when full.
        run(2'd0, uc(MA, 12'd10, 4'd5, 3'd6), '0, '0, "R4");
        check("R4", "update when full ok", 96'(ok), 96'(1));
        check("R4", "update when full index", 96'(rsp_index), 96'(0));
        run(2'd1, uc(MA, 12'd10, 4'd0, 3'd0), '0, '0, "R4");
        check("R4", "updated entry", rsp_entry, uc(MA, 12'd10, 4'd5, 3'd6));

        // R9: a miss leaves the response outputs unchanged.
        idx_before = rsp_index;
        ent_before = rsp_entry;
        run(2'd1, uc(MZ, 12'd99, 4'd0, 3'd0), '0, '0, "R9");
        check("R9", "miss flagged", 96'(not_found), 96'(1));
        check("R9", "index held", 96'(rsp_index), 96'(idx_before));
        check("R9", "entry held", rsp_entry, ent_before);

        // Free slot 5 for the next test.
        run(2'd0, uc(48'h0000_0000_1001, 12'd30, 4'd0, 3'd0), '0, '0, "R6");
        check("R6", "remove slot 5", 96'(rsp_index), 96'(5));

        // R10: a start during a scan is ignored; exactly one done follows.
        @(negedge clk);
        cmd_start = 1'b1; cmd_op = 2'd1; cmd_entry = uc(MZ, 12'd77, 4'd0, 3'd0);
        @(negedge clk);
        cmd_start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        cmd_start = 1'b1; cmd_op = 2'd0; cmd_entry = uc(48'h0000_0000_3000, 12'd40, 4'd1, 3'd2);
        @(negedge clk);
        cmd_start = 1'b0;
        n_done = 0;
        nf_seen = 1'b0;
        for (int w = 0; w < TB_DEPTH + 6; w++) begin
            if (done) begin
                n_done++;
                nf_seen = not_found;
            end
            @(negedge clk);
        end
        check("R10", "single done pulse", 96'(n_done), 96'(1));
        check("R10", "first command result", 96'(nf_seen), 96'(1));
        run(2'd1, uc(48'h0000_0000_3000, 12'd40, 4'd0, 3'd0), '0, '0, "R10");
        check("R10", "ignored write absent", 96'(not_found), 96'(1));

        finish_up();
    end

endmodule